// File: doc/BRIEF.md
# Packed SIMD Saturating Lane ALU

This block performs one arithmetic, shift, compare or select operation on a 32-bit word that holds several independent lanes. The word holds either four 8-bit lanes or two 16-bit lanes, with lane 0 in the least significant bits. Each lane is computed on its own. Lanes are sign-extended or zero-extended as the signedness flag selects, and each lane clamps and reports overflow without reference to its neighbours.

An operation is presented with `in_valid`. Its packed result appears one clock later with `out_valid`. Two pieces of state persist between operations. The first is an 8-bit sticky overflow field that reports arithmetic overflow in bit 4 and left-shift overflow in bit 6. The second is a 4-bit condition field written by compares. The pick operation later reads the condition field to choose each lane from one of the two operands. A write port replaces the overflow field and is the only way, apart from reset, to clear it.

Top module: `simd_lane_alu`

## Requirements
- R1: `fmt`=0 treats the operands as four 8-bit lanes and `fmt`=1 as two 16-bit lanes. Lane i occupies bits [i*W+W-1 : i*W], and no lane's result depends on another lane's inputs.
- R2: With `saturate`=1, add (op 0) and subtract (op 1) clamp each lane to the range of its type. The signed range is -2^(W-1)..2^(W-1)-1 and the unsigned range is 0..2^W-1.
- R3: With `saturate`=0, add and subtract keep the low W bits of the exact lane result. Overflow in any active lane of an add, subtract or absolute value sets overflow flag bit 4 regardless of `saturate`.
- R4: Halving add (op 2) and halving subtract (op 3) return floor((a±b+r)/2) per lane, where r=1 when `round_en`=1 and r=0 otherwise. These operations never set an overflow flag.
- R5: Absolute value (op 4) always treats lanes as signed and ignores operand b. It maps the most negative lane value to the most positive value and sets flag bit 4. Other negative lanes are negated and non-negative lanes pass through.
- R6: Left shift (op 5) uses `shamt[2:0]` for byte lanes and `shamt[3:0]` for halfword lanes. Overflow against the lane range sets flag bit 6. With `saturate`=1 the lane clamps; otherwise it keeps the low W bits.
- R7: Logical right shift (op 6) treats lanes as unsigned. Arithmetic right shift (op 7) treats lanes as signed and, when `round_en`=1 and the masked shift s>0, adds 2^(s-1) before shifting.
- R8: Compares equal (op 8), less-than (op 9) and less-or-equal (op 10) follow the signedness flag and return a zero result. The outcome for lane i is written to `cond_bits[i]`. In halfword mode only bits 1:0 are written and bits 3:2 keep their value.
- R9: Pick (op 11) returns lane i of `opa` when `cond_bits[i]`=1 and lane i of `opb` otherwise. The condition bits it uses are those held before the pick is applied.
- R10: Overflow flags are only ORed in. When `flag_wr`=1, the field is loaded with `flag_wdata` ORed with the flags raised by an operation in the same cycle. Bits other than 4 and 6 change only through that write.
- R11: `out_valid` equals `in_valid` delayed by one clock. `result` and the state fields update at the same edge, and `result` holds its value while `in_valid`=0.
- R12: Synchronous active-high reset clears `result`, `ovf_flags`, `cond_bits` and `out_valid`. Op codes 12 to 15 return zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| fmt | input | 1 | Lane format: 0 = four bytes, 1 = two halfwords |
| is_signed | input | 1 | Lanes are signed |
| saturate | input | 1 | Clamp instead of wrap |
| round_en | input | 1 | Rounding for halving ops and arithmetic right shift |
| shamt | input | 4 | Shift amount before masking to the lane width |
| opa | input | 32 | Operand a |
| opb | input | 32 | Operand b |
| flag_wr | input | 1 | Load the overflow field |
| flag_wdata | input | 8 | Value for the overflow field |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered packed result |
| ovf_flags | output | 8 | Sticky overflow field |
| cond_bits | output | 4 | Per-lane condition bits |

## Verification
The hardest case to reach is a pick that reads condition bits left by a compare in the other lane format. Examples are a halfword compare that must leave the upper two bits from an earlier byte compare, or a byte pick that follows it. The stimulus reaches these cases in two ways. The sweeps interleave compares and picks across formats while the bench carries its own model of the condition field. Directed sequences also set all four bits, then run a halfword compare and a byte pick. Lane values at the signed and unsigned limits are injected into random words so that each lane overflows on its own.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int WORD_W         = 32;
    localparam int BYTE_W         = 8;
    localparam int HALF_W         = 16;
    localparam int N_BYTE         = WORD_W / BYTE_W;
    localparam int N_HALF         = WORD_W / HALF_W;
    localparam int BYTE_SW        = $clog2(BYTE_W);
    localparam int HALF_SW        = $clog2(HALF_W);
    localparam int SHAMT_W        = HALF_SW;
    localparam int FLAG_W         = 8;
    localparam int COND_W         = N_BYTE;
    localparam int FLAG_ARITH_BIT = 4;
    localparam int FLAG_SHIFT_BIT = 6;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_HADD  = 4'd2,
        OP_HSUB  = 4'd3,
        OP_ABS   = 4'd4,
        OP_SHL   = 4'd5,
        OP_SHRL  = 4'd6,
        OP_SHRA  = 4'd7,
        OP_CMPEQ = 4'd8,
        OP_CMPLT = 4'd9,
        OP_CMPLE = 4'd10,
        OP_PICK  = 4'd11
    } alu_op_e;

    typedef enum logic {
        FMT_BYTE = 1'b0,
        FMT_HALF = 1'b1
    } lane_fmt_e;

    typedef struct packed {
        logic sgn;
        logic sat;
        logic rnd;
    } lane_ctl_t;

    function automatic logic is_compare(alu_op_e op);
        return (op == OP_CMPEQ) || (op == OP_CMPLT) || (op == OP_CMPLE);
    endfunction

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e                 op,
    input  lane_ctl_t               ctl,
    input  logic [$clog2(W)-1:0]    sa,
    input  logic [W-1:0]            a,
    input  logic [W-1:0]            b,
    input  logic                    pick_a,
    output logic [W-1:0]            res,
    output logic                    ovf_arith,
    output logic                    ovf_shift,
    output logic                    cc
);

    localparam int EW = 2 * W + 2;
    localparam logic signed [EW-1:0] ONE  = {{(EW-1){1'b0}}, 1'b1};
    localparam logic signed [EW-1:0] SMAX = {{(EW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [EW-1:0] SMIN = ~SMAX;
    localparam logic signed [EW-1:0] UMAX = {{(EW-W){1'b0}}, {W{1'b1}}};

    logic signed [EW-1:0] ea, eb, sa_a, hi, lo, t, tr;

    always_comb begin
        ea   = ctl.sgn ? {{(EW-W){a[W-1]}}, a} : {{(EW-W){1'b0}}, a};
        eb   = ctl.sgn ? {{(EW-W){b[W-1]}}, b} : {{(EW-W){1'b0}}, b};
        sa_a = {{(EW-W){a[W-1]}}, a};
        hi   = ctl.sgn ? SMAX : UMAX;
        lo   = ctl.sgn ? SMIN : '0;
        t         = '0;
        tr        = '0;
        res       = '0;
        ovf_arith = 1'b0;
        ovf_shift = 1'b0;
        cc        = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                t = (op == OP_ADD) ? ea + eb : ea - eb;
                ovf_arith = (t > hi) || (t < lo);
                if (ctl.sat && (t > hi))      res = hi[W-1:0];
                else if (ctl.sat && (t < lo)) res = lo[W-1:0];
                else                          res = t[W-1:0];
            end
            OP_HADD, OP_HSUB: begin
                t = (op == OP_HADD) ? ea + eb : ea - eb;
                if (ctl.rnd) t = t + ONE;
                tr  = t >>> 1;
                res = tr[W-1:0];
            end
            OP_ABS: begin
                if (sa_a == SMIN) begin
                    res       = SMAX[W-1:0];
                    ovf_arith = 1'b1;
                end else if (sa_a[EW-1]) begin
                    t   = -sa_a;
                    res = t[W-1:0];
                end else begin
                    res = a;
                end
            end
            OP_SHL: begin
                t = ea <<< sa;
                ovf_shift = (t > hi) || (t < lo);
                if (ctl.sat && (t > hi))      res = hi[W-1:0];
                else if (ctl.sat && (t < lo)) res = lo[W-1:0];
                else                          res = t[W-1:0];
            end
            OP_SHRL: res = a >> sa;
            OP_SHRA: begin
                if (ctl.rnd && (sa != '0)) tr = ONE <<< (sa - 1'b1);
                t   = sa_a + tr;
                tr  = t >>> sa;
                res = tr[W-1:0];
            end
            OP_CMPEQ: cc = (ea == eb);
            OP_CMPLT: cc = (ea < eb);
            OP_CMPLE: cc = (ea <= eb);
            OP_PICK:  res = pick_a ? a : b;
            default:  ;
        endcase
    end

    // absolute value never yields a negative lane
    always_comb begin
        if (op == OP_ABS) begin
            assert_abs_nonneg_R5: assert (!res[W-1])
                else $error("absolute value produced negative lane");
        end
    end

endmodule

// File: rtl/simd_flag_state.sv
module simd_flag_state
    import simd_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              set_arith,
    input  logic              set_shift,
    input  logic              wr,
    input  logic [FLAG_W-1:0] wdata,
    input  logic              cc_upd,
    input  logic [COND_W-1:0] cc_mask,
    input  logic [COND_W-1:0] cc_new,
    output logic [FLAG_W-1:0] flags_q,
    output logic [COND_W-1:0] cond_q
);

    localparam logic [FLAG_W-1:0] LIVE_MASK =
        FLAG_W'(1 << FLAG_ARITH_BIT) | FLAG_W'(1 << FLAG_SHIFT_BIT);

    logic [FLAG_W-1:0] newset;

    always_comb begin
        newset = '0;
        newset[FLAG_ARITH_BIT] = upd & set_arith;
        newset[FLAG_SHIFT_BIT] = upd & set_shift;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            cond_q  <= '0;
        end else begin
            flags_q <= (wr ? wdata : flags_q) | newset;
            if (cc_upd) cond_q <= (cond_q & ~cc_mask) | (cc_new & cc_mask);
        end
    end

    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_flags_idle_bits_R10: assert property (@(posedge clk) disable iff (rst)
        !wr |=> (((flags_q ^ $past(flags_q)) & ~LIVE_MASK) == '0));

    assert_cond_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cc_upd |=> $stable(cond_q));

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  op,
    input  logic        fmt,
    input  logic        is_signed,
    input  logic        saturate,
    input  logic        round_en,
    input  logic [3:0]  shamt,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic        flag_wr,
    input  logic [7:0]  flag_wdata,
    output logic        out_valid,
    output logic [31:0] result,
    output logic [7:0]  ovf_flags,
    output logic [3:0]  cond_bits
);

    alu_op_e           op_e;
    lane_fmt_e         fmt_e;
    lane_ctl_t         ctl;
    logic [WORD_W-1:0] b_res, h_res, res_d;
    logic [N_BYTE-1:0] b_ova, b_ovs, b_cc;
    logic [N_HALF-1:0] h_ova, h_ovs, h_cc;
    logic              set_arith, set_shift;
    logic [COND_W-1:0] cc_new, cc_mask, cond_q;

    assign op_e  = alu_op_e'(op);
    assign fmt_e = lane_fmt_e'(fmt);
    assign ctl   = '{sgn: is_signed, sat: saturate, rnd: round_en};

    for (genvar i = 0; i < N_BYTE; i++) begin : g_byte
        simd_lane_unit #(.W(BYTE_W)) u_lane (
            .op        (op_e),
            .ctl       (ctl),
            .sa        (shamt[BYTE_SW-1:0]),
            .a         (opa[i*BYTE_W +: BYTE_W]),
            .b         (opb[i*BYTE_W +: BYTE_W]),
            .pick_a    (cond_q[i]),
            .res       (b_res[i*BYTE_W +: BYTE_W]),
            .ovf_arith (b_ova[i]),
            .ovf_shift (b_ovs[i]),
            .cc        (b_cc[i])
        );
    end

    for (genvar j = 0; j < N_HALF; j++) begin : g_half
        simd_lane_unit #(.W(HALF_W)) u_lane (
            .op        (op_e),
            .ctl       (ctl),
            .sa        (shamt[HALF_SW-1:0]),
            .a         (opa[j*HALF_W +: HALF_W]),
            .b         (opb[j*HALF_W +: HALF_W]),
            .pick_a    (cond_q[j]),
            .res       (h_res[j*HALF_W +: HALF_W]),
            .ovf_arith (h_ova[j]),
            .ovf_shift (h_ovs[j]),
            .cc        (h_cc[j])
        );
    end

    always_comb begin
        if (fmt_e == FMT_HALF) begin
            res_d     = h_res;
            set_arith = |h_ova;
            set_shift = |h_ovs;
            cc_new    = COND_W'(h_cc);
            cc_mask   = COND_W'({N_HALF{1'b1}});
        end else begin
            res_d     = b_res;
            set_arith = |b_ova;
            set_shift = |b_ovs;
            cc_new    = b_cc;
            cc_mask   = {COND_W{1'b1}};
        end
    end

    simd_flag_state u_state (
        .clk       (clk),
        .rst       (rst),
        .upd       (in_valid),
        .set_arith (set_arith),
        .set_shift (set_shift),
        .wr        (flag_wr),
        .wdata     (flag_wdata),
        .cc_upd    (in_valid && is_compare(op_e)),
        .cc_mask   (cc_mask),
        .cc_new    (cc_new),
        .flags_q   (ovf_flags),
        .cond_q    (cond_q)
    );

    assign cond_bits = cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= res_d;
        end
    end

    assert_valid_follow_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    assert_half_cond_upper_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt) |=> (cond_bits[3:2] == $past(cond_bits[3:2])));

endmodule

// File: tb/tb_simd_lane_alu.sv
`timescale 1ns/1ps
module tb_simd_lane_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        fmt = 1'b0, is_signed = 1'b0, saturate = 1'b0, round_en = 1'b0;
    logic [3:0]  shamt = '0;
    logic [31:0] opa = '0, opb = '0;
    logic        flag_wr = 1'b0;
    logic [7:0]  flag_wdata = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [7:0]  ovf_flags;
    logic [3:0]  cond_bits;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [31:0] m_res = '0;
    logic [7:0]  m_flags = '0;
    logic [3:0]  m_cond = '0;

    always #4 clk = ~clk;

    simd_lane_alu dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .fmt(fmt),
        .is_signed(is_signed), .saturate(saturate), .round_en(round_en),
        .shamt(shamt), .opa(opa), .opb(opb), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .out_valid(out_valid), .result(result),
        .ovf_flags(ovf_flags), .cond_bits(cond_bits)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic string op_tag(input int o);
        case (o)
            0, 1:      return "R2";
            2, 3:      return "R4";
            4:         return "R5";
            5:         return "R6";
            6, 7:      return "R7";
            8, 9, 10:  return "R8";
            11:        return "R9";
            default:   return "R12";
        endcase
    endfunction

    // Arithmetic lane model
    task automatic model_lane(input int o, input int w, input bit sg, input bit st,
                              input bit rd, input int sh, input longint ua,
                              input longint ub, input bit pk, output longint r,
                              output bit f4, output bit f6, output bit c);
        longint full, half, sva, svb, ea, eb, hi, lo, t, mask;
        int s;
        full = longint'(1) << w;
        half = longint'(1) << (w - 1);
        mask = full - 1;
        sva = (ua >= half) ? ua - full : ua;
        svb = (ub >= half) ? ub - full : ub;
        ea = sg ? sva : ua;
        eb = sg ? svb : ub;
        hi = sg ? half - 1 : full - 1;
        lo = sg ? -half : 0;
        s = (w == 8) ? (sh & 7) : (sh & 15);
        r = 0; f4 = 0; f6 = 0; c = 0;
        case (o)
            0, 1: begin
                t = (o == 0) ? ea + eb : ea - eb;
                f4 = (t > hi) || (t < lo);
                if (st && t > hi) t = hi;
                if (st && t < lo) t = lo;
                r = t & mask;
            end
            2, 3: begin
                t = ((o == 2) ? ea + eb : ea - eb) + (rd ? 1 : 0);
                r = (t >>> 1) & mask;
            end
            4: begin
                if (sva == -half) begin r = half - 1; f4 = 1; end
                else if (sva < 0) r = -sva;
                else r = sva;
            end
            5: begin
                t = ea * (longint'(1) << s);
                f6 = (t > hi) || (t < lo);
                if (st && t > hi) t = hi;
                if (st && t < lo) t = lo;
                r = t & mask;
            end
            6: r = ua >> s;
            7: begin
                t = sva + ((rd && s > 0) ? (longint'(1) << (s - 1)) : 0);
                r = (t >>> s) & mask;
            end
            8:  c = (ea == eb);
            9:  c = (ea < eb);
            10: c = (ea <= eb);
            11: r = pk ? ua : ub;
            default: r = 0;
        endcase
    endtask

    task automatic do_op(input string tag, input int o, input bit f, input bit sg,
                         input bit st, input bit rd, input int sh,
                         input logic [31:0] a, input logic [31:0] b,
                         input bit wr, input logic [7:0] wd);
        longint r;
        bit f4, f6, c;
        logic [7:0] newf = '0;
        logic [3:0] cn = m_cond;
        logic [31:0] er = '0;
        if (f == 0) begin
            for (int i = 0; i < 4; i++) begin
                model_lane(o, 8, sg, st, rd, sh, longint'(a[i*8 +: 8]),
                           longint'(b[i*8 +: 8]), m_cond[i], r, f4, f6, c);
                er[i*8 +: 8] = r[7:0];
                newf[4] |= f4; newf[6] |= f6; cn[i] = c;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                model_lane(o, 16, sg, st, rd, sh, longint'(a[i*16 +: 16]),
                           longint'(b[i*16 +: 16]), m_cond[i], r, f4, f6, c);
                er[i*16 +: 16] = r[15:0];
                newf[4] |= f4; newf[6] |= f6; cn[i] = c;
            end
        end
        if (o >= 8 && o <= 10) m_cond = cn;
        m_flags = (wr ? wd : m_flags) | newf;
        m_res = er;
        op = 4'(o); fmt = f; is_signed = sg; saturate = st; round_en = rd;
        shamt = 4'(sh); opa = a; opb = b; flag_wr = wr; flag_wdata = wd;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; flag_wr = 1'b0;
        chk(tag, "result", result, m_res);
        chk(tag, "ovf_flags", {24'd0, ovf_flags}, {24'd0, m_flags});
        chk(tag, "cond_bits", {28'd0, cond_bits}, {28'd0, m_cond});
        chk("R11", "out_valid", {31'd0, out_valid}, 32'd1);
    endtask

    function automatic logic [31:0] mk_word();
        logic [31:0] v = $urandom;
        logic [7:0] bc [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
        for (int i = 0; i < 4; i++)
            if ($urandom % 3 == 0) v[i*8 +: 8] = bc[$urandom % 4];
        if ($urandom % 4 == 0) v[15:0]  = ($urandom % 2) ? 16'h8000 : 16'h7FFF;
        if ($urandom % 4 == 0) v[31:16] = ($urandom % 2) ? 16'h8000 : 16'hFFFF;
        return v;
    endfunction

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "reset result", result, 32'd0);
        chk("R12", "reset flags", {24'd0, ovf_flags}, 32'd0);
        chk("R12", "reset cond", {28'd0, cond_bits}, 32'd0);
        chk("R12", "reset valid", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1: lane placement, no carry between lanes
        do_op("R1", 0, 0, 0, 0, 0, 0, 32'h01020304, 32'h10203040, 1, 8'h00);
        chk("R1", "byte lanes", result, 32'h11223344);
        do_op("R1", 0, 0, 0, 0, 0, 0, 32'h00FF0000, 32'h00010000, 1, 8'h00);
        chk("R1", "no carry to lane 3", result, 32'h00000000);
        // R3: wrap still flags bit 4
        chk("R3", "wrap flag", {24'd0, ovf_flags}, 32'h10);
        do_op("R1", 1, 1, 1, 0, 0, 0, 32'h00050003, 32'h00020007, 1, 8'h00);
        chk("R1", "half lanes", result, 32'h0003FFFC);

        // R10: sticky flags
        do_op("R10", 0, 0, 1, 1, 0, 0, 32'h0000007F, 32'h00000001, 0, 8'h00);
        do_op("R10", 0, 0, 1, 1, 0, 0, 32'h00000001, 32'h00000001, 0, 8'h00);
        chk("R10", "arith flag kept", {24'd0, ovf_flags}, 32'h10);
        do_op("R10", 5, 1, 1, 0, 0, 4, 32'h00004000, 32'h0, 0, 8'h00);
        chk("R10", "shift flag joins", {24'd0, ovf_flags}, 32'h50);
        flag_wr = 1'b1; flag_wdata = 8'h01;
        @(negedge clk);
        flag_wr = 1'b0; m_flags = 8'h01;
        chk("R10", "explicit write", {24'd0, ovf_flags}, 32'h01);
        // R11: idle cycle holds result, drops valid
        chk("R11", "idle valid", {31'd0, out_valid}, 32'd0);
        chk("R11", "idle hold", result, m_res);

        // R8 / R9: format mixing of condition bits
        do_op("R8", 8, 0, 0, 0, 0, 0, 32'h11223344, 32'h11223344, 0, 8'h00);
        chk("R8", "all equal", {28'd0, cond_bits}, 32'hF);
        do_op("R8", 9, 1, 0, 0, 0, 0, 32'h00090009, 32'h00010001, 0, 8'h00);
        chk("R8", "half keeps upper", {28'd0, cond_bits}, 32'hC);
        do_op("R9", 11, 0, 0, 0, 0, 0, 32'hAABBCCDD, 32'h11223344, 0, 8'h00);
        chk("R9", "byte pick", result, 32'hAABB3344);

        // R12: unused codes
        do_op("R12", 13, 0, 1, 1, 1, 3, 32'h7F7F7F7F, 32'h7F7F7F7F, 0, 8'h00);
        chk("R12", "unused op result", result, 32'd0);

        // Sweeps over all ops, formats and flag combinations
        for (int o = 0; o < 12; o++)
            for (int f = 0; f < 2; f++)
                for (int m = 0; m < 8; m++)
                    for (int k = 0; k < 40; k++) begin
                        logic [31:0] wa = mk_word();
                        logic [31:0] wb = (k % 5 == 0) ? wa : mk_word();
                        do_op(op_tag(o), o, f[0], m[0], m[1], m[2],
                              int'($urandom % 16), wa, wb,
                              (k % 7 != 3), 8'h00);
                        // interleave compares so picks see mixed state
                        if (o == 11 && k % 4 == 0)
                            do_op("R8", 9, !f[0], m[0], 0, 0, 0, mk_word(),
                                  mk_word(), 1, 8'h00);
                    end

        finish_run();
    end

endmodule